// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block pairs two eight-line request resolvers into one sixteen-line interrupt controller. Lines 0 to 7 feed the primary resolver and lines 8 to 15 feed the secondary one. Whenever the secondary resolver has a request it would present, it sets a fresh edge on primary input 2. The single processor interrupt line then shows whether the primary resolver has a request to present. When the processor pulses the acknowledge strobe, the block walks down the cascade and registers an 8-bit vector. A spurious acknowledge on either resolver is answered with that resolver's base plus index 7.

Each resolver has a request latch, an in-service set, a mask, a programmed vector base, and a small programming sequencer with the states `U_RUN`, `U_GET_BASE`, `U_GET_CASC` and `U_GET_MODE`. A start command moves it from `U_RUN` to `U_GET_BASE`. The next data write moves it from `U_GET_BASE` to `U_GET_CASC`. From `U_GET_CASC` a data write moves it to `U_GET_MODE` when the start command asked for a fourth word, and to `U_RUN` otherwise. From `U_GET_MODE` a data write moves it to `U_RUN`. The acknowledge path has two states: `VEC_IDLE` and `VEC_SHOW`. Any clock edge with the strobe high enters `VEC_SHOW`, and any edge with the strobe low returns to `VEC_IDLE`. Priority is fixed, with line 0 highest. The byte-wide I/O map is: 0x0020/0x0021 reach the primary resolver, 0x00A0/0x00A1 reach the secondary one, and 0x04D0/0x04D1 reach the primary and secondary trigger-mode registers. Reads are combinational while the read strobe is high.

Top module: `irq_cascade_pair`

## Requirements
- R1: After reset, `int_o` and `vec_vld_o` are low, both masks read 0x00, and both trigger-mode registers read 0x00.
- R2: On a line whose trigger bit is 0, a rising edge latches a request that raises `int_o` after one clock edge. A line that stays high produces no further request.
- R3: The lowest pending unmasked index wins. A pending index equal to or above the lowest in-service index is not presented.
- R4: A write to the odd address of a resolver in `U_RUN` sets its mask, and a read of that address returns it. Masked requests stay latched but do not raise `int_o`.
- R5: A clock edge with `inta_i` high gives `vec_vld_o` high for the next cycle, with `vec_o` holding the vector. On that same edge the winner's in-service bit is set, and its request is cleared if it is edge-triggered. `vec_o` changes only on such edges.
- R6: A pending request on the secondary resolver raises `int_o` through primary input 2 within two edges. Acknowledging it yields secondary base plus the secondary winner.
- R7: An acknowledge while the primary resolver presents nothing yields primary base plus 7.
- R8: An acknowledge where the primary winner is input 2 but the secondary resolver presents nothing yields secondary base plus 7.
- R9: Even-address command bytes are decoded as follows. 0x20 clears the lowest in-service bit. 0x60+n clears in-service bit n. 0x0B selects the in-service set for even-address reads, and 0x0A selects the request latch.
- R10: Writes to 0x04D0 are ANDed with 0xF8 and writes to 0x04D1 with 0xDE. Reads return the stored value.
- R11: On a line whose trigger bit is 1, the request follows the line level and is not cleared by acknowledge.
- R12: An even-address byte with bit 4 set clears the mask and starts programming. The next odd write sets the base (low three bits dropped). The one after is consumed, and if bit 0 of the start byte was set, a third is consumed too.
- R13: Writes outside the map change nothing, and reads outside the map return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 16 | Request lines; 7:0 primary, 15:8 secondary |
| io_addr_i | input | 16 | I/O byte address |
| io_wdata_i | input | 8 | Write data |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_rdata_o | output | 8 | Read data, zero when not reading |
| inta_i | input | 1 | Acknowledge strobe |
| int_o | output | 1 | Processor interrupt line |
| vec_o | output | 8 | Acknowledge vector |
| vec_vld_o | output | 1 | Vector valid, one cycle after the strobe |

## Verification
The hardest case to reach is the secondary spurious vector. It needs primary input 2 latched while the secondary resolver no longer presents anything, and the normal cascade path never leaves that state behind. The stimulus raises a secondary line, waits until the cascade edge has reached the primary resolver, and then masks that line on the secondary resolver before acknowledging. The bench then unmasks the line and confirms that the still-latched request is delivered with its real vector.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
    typedef enum logic [1:0] {
        U_RUN,
        U_GET_BASE,
        U_GET_CASC,
        U_GET_MODE
    } unit_state_e;

    typedef enum logic {
        VEC_IDLE,
        VEC_SHOW
    } vec_state_e;
endpackage

// File: rtl/pic_io_decode.sv
module pic_io_decode #(
    parameter int         ADDR_W      = 16,
    parameter logic [15:0] MASTER_ADDR = 16'h0020,
    parameter logic [15:0] SLAVE_ADDR  = 16'h00A0,
    parameter logic [15:0] TRIG_ADDR   = 16'h04D0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_m_o,
    output logic              hit_s_o,
    output logic              hit_t_o,
    output logic              odd_o
);
    // Each window is a byte pair; bit 0 picks the register inside it.
    assign hit_m_o = (addr_i[ADDR_W-1:1] == MASTER_ADDR[ADDR_W-1:1]);
    assign hit_s_o = (addr_i[ADDR_W-1:1] == SLAVE_ADDR[ADDR_W-1:1]);
    assign hit_t_o = (addr_i[ADDR_W-1:1] == TRIG_ADDR[ADDR_W-1:1]);
    assign odd_o   = addr_i[0];
endmodule

// File: rtl/pic_trig_regs.sv
module pic_trig_regs #(
    parameter int         LINES   = 8,
    parameter logic [7:0] KEEP_M  = 8'hF8,
    parameter logic [7:0] KEEP_S  = 8'hDE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic                  sel_i,
    input  logic [LINES-1:0]      wdata_i,
    output logic [1:0][LINES-1:0] trig_o
);
    for (genvar g = 0; g < 2; g++) begin : g_reg
        localparam logic [LINES-1:0] KEEP = (g == 0) ? KEEP_M[LINES-1:0] : KEEP_S[LINES-1:0];
        logic [LINES-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_i && (sel_i == g[0])) begin
                val_q <= wdata_i & KEEP;
            end
        end
        assign trig_o[g] = val_q;
    end
endmodule

// File: rtl/pic_resolver_unit.sv
module pic_resolver_unit
    import pic_cascade_pkg::*;
#(
    parameter int         LINES      = 8,
    parameter logic [7:0] RESET_BASE = 8'h08
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LINES-1:0]         req_lvl_i,
    input  logic [LINES-1:0]         force_set_i,
    input  logic [LINES-1:0]         trig_i,
    input  logic                     wr_i,
    input  logic                     odd_i,
    input  logic [7:0]               wdata_i,
    input  logic                     ack_i,
    output logic                     valid_o,
    output logic [$clog2(LINES)-1:0] win_o,
    output logic [7:0]               base_o,
    output logic [7:0]               rd_even_o,
    output logic [7:0]               rd_odd_o
);
    localparam int         IDX_W     = $clog2(LINES);
    localparam int         PRI_W     = IDX_W + 1;
    localparam logic [PRI_W-1:0] NONE = PRI_W'(LINES);
    localparam logic [7:0] BASE_KEEP = ~8'(LINES - 1);

    unit_state_e      state_q, state_d;
    logic [LINES-1:0] irr_q, irr_d, isr_q, isr_d, mask_q, mask_d, prev_q, prev_d;
    logic [7:0]       base_q, base_d;
    logic             need_mode_q, need_mode_d, show_isr_q, show_isr_d;
    logic [PRI_W-1:0] pend_pri, serv_pri;
    logic [LINES-1:0] pending, rise, ack_bit, clr;
    logic             cmd_wr, data_wr, is_init, is_sel, eoi_any, eoi_one;

    assign pending = irr_q & ~mask_q;

    // Fixed priority search: index 0 is the most urgent.
    always_comb begin
        pend_pri = NONE;
        serv_pri = NONE;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pending[i]) pend_pri = PRI_W'(i);
            if (isr_q[i])   serv_pri = PRI_W'(i);
        end
    end

    assign valid_o = (pend_pri < serv_pri);
    assign win_o   = pend_pri[IDX_W-1:0];
    assign base_o  = base_q;

    assign cmd_wr  = wr_i & ~odd_i;
    assign data_wr = wr_i & odd_i;
    assign is_init = cmd_wr & wdata_i[4];
    assign is_sel  = cmd_wr & ~wdata_i[4] & wdata_i[3];
    assign eoi_any = cmd_wr & ~wdata_i[4] & ~wdata_i[3] & (wdata_i[7:5] == 3'b001);
    assign eoi_one = cmd_wr & ~wdata_i[4] & ~wdata_i[3] & (wdata_i[7:5] == 3'b011);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= U_RUN;
            irr_q       <= '0;
            isr_q       <= '0;
            mask_q      <= '0;
            prev_q      <= '0;
            base_q      <= RESET_BASE & BASE_KEEP;
            need_mode_q <= 1'b0;
            show_isr_q  <= 1'b0;
        end else begin
            state_q     <= state_d;
            irr_q       <= irr_d;
            isr_q       <= isr_d;
            mask_q      <= mask_d;
            prev_q      <= prev_d;
            base_q      <= base_d;
            need_mode_q <= need_mode_d;
            show_isr_q  <= show_isr_d;
        end
    end

    // Next-state and datapath update
    always_comb begin
        state_d     = state_q;
        base_d      = base_q;
        mask_d      = mask_q;
        need_mode_d = need_mode_q;
        show_isr_d  = show_isr_q;
        prev_d      = req_lvl_i;
        rise        = req_lvl_i & ~prev_q;
        ack_bit     = '0;
        clr         = '0;
        if (ack_i && valid_o) ack_bit[win_o] = 1'b1;
        irr_d = (((irr_q & ~ack_bit) | rise | force_set_i) & ~trig_i) | (req_lvl_i & trig_i);
        if (eoi_any && (serv_pri != NONE)) clr[serv_pri[IDX_W-1:0]] = 1'b1;
        if (eoi_one) clr[wdata_i[IDX_W-1:0]] = 1'b1;
        isr_d = (isr_q | ack_bit) & ~clr;

        if (is_init) begin
            mask_d      = '0;
            irr_d       = req_lvl_i & trig_i;
            prev_d      = '0;
            show_isr_d  = 1'b0;
            need_mode_d = wdata_i[0];
            state_d     = U_GET_BASE;
        end else if (is_sel && wdata_i[1]) begin
            show_isr_d = wdata_i[0];
        end

        if (data_wr) begin
            unique case (state_q)
                U_RUN:      mask_d  = wdata_i[LINES-1:0];
                U_GET_BASE: begin
                    base_d  = wdata_i & BASE_KEEP;
                    state_d = U_GET_CASC;
                end
                U_GET_CASC: state_d = need_mode_q ? U_GET_MODE : U_RUN;
                U_GET_MODE: state_d = U_RUN;
            endcase
        end
    end

    // Read outputs
    always_comb begin
        rd_even_o = show_isr_q ? 8'(isr_q) : 8'(irr_q);
        rd_odd_o  = 8'(mask_q);
    end
endmodule

// File: rtl/irq_cascade_pair.sv
module irq_cascade_pair
    import pic_cascade_pkg::*;
#(
    parameter int          UNIT_LINES     = 8,
    parameter int          CASCADE_LINE   = 2,
    parameter logic [15:0] MASTER_ADDR    = 16'h0020,
    parameter logic [15:0] SLAVE_ADDR     = 16'h00A0,
    parameter logic [15:0] TRIG_ADDR      = 16'h04D0,
    parameter logic [7:0]  MASTER_KEEP    = 8'hF8,
    parameter logic [7:0]  SLAVE_KEEP     = 8'hDE,
    parameter logic [7:0]  MASTER_RST_BASE = 8'h08,
    parameter logic [7:0]  SLAVE_RST_BASE  = 8'h70
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*UNIT_LINES-1:0] req_i,
    input  logic [15:0]             io_addr_i,
    input  logic [7:0]              io_wdata_i,
    input  logic                    io_wr_i,
    input  logic                    io_rd_i,
    output logic [7:0]              io_rdata_o,
    input  logic                    inta_i,
    output logic                    int_o,
    output logic [7:0]              vec_o,
    output logic                    vec_vld_o
);
    localparam int               IDX_W    = $clog2(UNIT_LINES);
    localparam logic [IDX_W-1:0] CASC_IDX = IDX_W'(CASCADE_LINE);
    localparam logic [7:0]       SPUR     = 8'(UNIT_LINES - 1);

    logic hit_m, hit_s, hit_t, odd;
    logic [1:0][UNIT_LINES-1:0] trig;
    logic [UNIT_LINES-1:0] m_force, s_force;
    logic m_valid, s_valid, s_ack;
    logic [IDX_W-1:0] m_win, s_win;
    logic [7:0] m_base, s_base, m_rd_even, m_rd_odd, s_rd_even, s_rd_odd;
    logic [7:0] vec_d, vec_q;
    vec_state_e vstate_q, vstate_d;

    pic_io_decode #(
        .ADDR_W(16), .MASTER_ADDR(MASTER_ADDR), .SLAVE_ADDR(SLAVE_ADDR), .TRIG_ADDR(TRIG_ADDR)
    ) u_dec (
        .addr_i(io_addr_i), .hit_m_o(hit_m), .hit_s_o(hit_s), .hit_t_o(hit_t), .odd_o(odd)
    );

    pic_trig_regs #(
        .LINES(UNIT_LINES), .KEEP_M(MASTER_KEEP), .KEEP_S(SLAVE_KEEP)
    ) u_trig (
        .clk(clk), .rst_n(rst_n), .wr_i(io_wr_i & hit_t), .sel_i(odd),
        .wdata_i(io_wdata_i[UNIT_LINES-1:0]), .trig_o(trig)
    );

    // The secondary's request pulses primary input 2; held off during the
    // acknowledge edge so the post-acknowledge state decides the next pulse.
    always_comb begin
        m_force               = '0;
        m_force[CASCADE_LINE] = s_valid & ~inta_i;
        s_force               = '0;
    end

    assign s_ack = inta_i & m_valid & (m_win == CASC_IDX);

    pic_resolver_unit #(.LINES(UNIT_LINES), .RESET_BASE(MASTER_RST_BASE)) u_master (
        .clk(clk), .rst_n(rst_n), .req_lvl_i(req_i[UNIT_LINES-1:0]), .force_set_i(m_force),
        .trig_i(trig[0]), .wr_i(io_wr_i & hit_m), .odd_i(odd), .wdata_i(io_wdata_i),
        .ack_i(inta_i), .valid_o(m_valid), .win_o(m_win), .base_o(m_base),
        .rd_even_o(m_rd_even), .rd_odd_o(m_rd_odd)
    );

    pic_resolver_unit #(.LINES(UNIT_LINES), .RESET_BASE(SLAVE_RST_BASE)) u_slave (
        .clk(clk), .rst_n(rst_n), .req_lvl_i(req_i[2*UNIT_LINES-1:UNIT_LINES]), .force_set_i(s_force),
        .trig_i(trig[1]), .wr_i(io_wr_i & hit_s), .odd_i(odd), .wdata_i(io_wdata_i),
        .ack_i(s_ack), .valid_o(s_valid), .win_o(s_win), .base_o(s_base),
        .rd_even_o(s_rd_even), .rd_odd_o(s_rd_odd)
    );

    assign int_o = m_valid;

    // Vector selection through the cascade
    always_comb begin
        if (!m_valid)              vec_d = m_base + SPUR;
        else if (m_win != CASC_IDX) vec_d = m_base + 8'(m_win);
        else if (s_valid)          vec_d = s_base + 8'(s_win);
        else                       vec_d = s_base + SPUR;
    end

    always_comb begin
        vstate_d = inta_i ? VEC_SHOW : VEC_IDLE;
    end

    // State register for the acknowledge path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vstate_q <= VEC_IDLE;
            vec_q    <= '0;
        end else begin
            vstate_q <= vstate_d;
            if (inta_i) vec_q <= vec_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (vstate_q)
            VEC_IDLE: vec_vld_o = 1'b0;
            VEC_SHOW: vec_vld_o = 1'b1;
        endcase
        vec_o      = vec_q;
        io_rdata_o = '0;
        if (io_rd_i) begin
            if (hit_m)      io_rdata_o = odd ? m_rd_odd : m_rd_even;
            else if (hit_s) io_rdata_o = odd ? s_rd_odd : s_rd_even;
            else if (hit_t) io_rdata_o = 8'(trig[odd]);
        end
    end
endmodule

// File: rtl/irq_cascade_pair_chk.sv
module irq_cascade_pair_chk #(
    parameter logic [15:0] MASTER_ADDR = 16'h0020,
    parameter logic [15:0] SLAVE_ADDR  = 16'h00A0,
    parameter logic [15:0] TRIG_ADDR   = 16'h04D0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        inta_i,
    input logic        int_o,
    input logic [7:0]  vec_o,
    input logic        vec_vld_o,
    input logic        io_rd_i,
    input logic [15:0] io_addr_i,
    input logic [7:0]  io_rdata_o
);
    logic in_map, trig_m_rd, trig_s_rd;
    assign in_map = (io_addr_i[15:1] == MASTER_ADDR[15:1]) ||
                    (io_addr_i[15:1] == SLAVE_ADDR[15:1]) ||
                    (io_addr_i[15:1] == TRIG_ADDR[15:1]);
    assign trig_m_rd = io_rd_i && (io_addr_i[15:1] == TRIG_ADDR[15:1]) && !io_addr_i[0];
    assign trig_s_rd = io_rd_i && (io_addr_i[15:1] == TRIG_ADDR[15:1]) && io_addr_i[0];

    p_ack_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inta_i |=> vec_vld_o);
    p_idle_novld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_i |=> !vec_vld_o);
    p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_i |=> $stable(vec_o));
    p_spur_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && !int_o) |=> (vec_o[2:0] == 3'd7));
    p_unmapped_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd_i || !in_map) |-> (io_rdata_o == 8'h00));
    p_trig_m_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_m_rd |-> (io_rdata_o[2:0] == 3'b000));
    p_trig_s_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_s_rd |-> ((io_rdata_o & 8'h21) == 8'h00));
endmodule

bind irq_cascade_pair irq_cascade_pair_chk #(
    .MASTER_ADDR(MASTER_ADDR), .SLAVE_ADDR(SLAVE_ADDR), .TRIG_ADDR(TRIG_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .inta_i(inta_i), .int_o(int_o), .vec_o(vec_o),
    .vec_vld_o(vec_vld_o), .io_rd_i(io_rd_i), .io_addr_i(io_addr_i), .io_rdata_o(io_rdata_o)
);

// File: tb/tb_irq_cascade_pair.sv
`timescale 1ns/1ps
module tb_irq_cascade_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_i = '0;
    logic [15:0] io_addr_i = '0;
    logic [7:0]  io_wdata_i = '0;
    logic        io_wr_i = 1'b0;
    logic        io_rd_i = 1'b0;
    logic [7:0]  io_rdata_o;
    logic        inta_i = 1'b0;
    logic        int_o;
    logic [7:0]  vec_o;
    logic        vec_vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_cascade_pair dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .io_addr_i(io_addr_i),
        .io_wdata_i(io_wdata_i), .io_wr_i(io_wr_i), .io_rd_i(io_rd_i),
        .io_rdata_o(io_rdata_o), .inta_i(inta_i), .int_o(int_o),
        .vec_o(vec_o), .vec_vld_o(vec_vld_o)
    );

    localparam logic [3:0] OP_WR = 4'd0, OP_RD = 4'd1, OP_ACK = 4'd2,
                           OP_REQ = 4'd3, OP_INT = 4'd4, OP_IDLE = 4'd5;

    function automatic logic [47:0] st(input logic [3:0] op, input logic [3:0] tag,
                                       input logic [15:0] addr, input logic [15:0] data,
                                       input logic [7:0] exp);
        return {op, tag, addr, data, exp};
    endfunction

    localparam int NSTEP = 55;
    localparam logic [47:0] STEPS [NSTEP] = '{
        st(OP_WR,  4'd10, 16'h04D0, 16'h00FF, 8'h00),
        st(OP_RD,  4'd10, 16'h04D0, 16'h0000, 8'hF8), // R10 primary keep mask
        st(OP_WR,  4'd10, 16'h04D1, 16'h00FF, 8'h00),
        st(OP_RD,  4'd10, 16'h04D1, 16'h0000, 8'hDE), // R10 secondary keep mask
        st(OP_WR,  4'd10, 16'h04D0, 16'h0000, 8'h00),
        st(OP_WR,  4'd10, 16'h04D1, 16'h0000, 8'h00),
        st(OP_WR,  4'd4,  16'h0021, 16'h00FF, 8'h00),
        st(OP_RD,  4'd4,  16'h0021, 16'h0000, 8'hFF), // R4 mask readback
        st(OP_WR,  4'd12, 16'h0020, 16'h0011, 8'h00), // R12 start, four words
        st(OP_WR,  4'd12, 16'h0021, 16'h0021, 8'h00), // base 0x20
        st(OP_WR,  4'd12, 16'h0021, 16'h0004, 8'h00),
        st(OP_WR,  4'd12, 16'h0021, 16'h0001, 8'h00),
        st(OP_RD,  4'd12, 16'h0021, 16'h0000, 8'h00), // R12 mask cleared, last word consumed
        st(OP_WR,  4'd12, 16'h00A0, 16'h0011, 8'h00),
        st(OP_WR,  4'd12, 16'h00A1, 16'h002F, 8'h00), // base 0x28
        st(OP_WR,  4'd12, 16'h00A1, 16'h0002, 8'h00),
        st(OP_WR,  4'd12, 16'h00A1, 16'h0001, 8'h00),
        st(OP_RD,  4'd12, 16'h00A1, 16'h0000, 8'h00),
        st(OP_REQ, 4'd2,  16'h0000, 16'h0010, 8'h00),
        st(OP_INT, 4'd2,  16'h0000, 16'h0000, 8'h01), // R2 edge raises int
        st(OP_REQ, 4'd3,  16'h0000, 16'h0012, 8'h00),
        st(OP_ACK, 4'd3,  16'h0000, 16'h0000, 8'h21), // R3 lowest index wins, R5 vector
        st(OP_INT, 4'd3,  16'h0000, 16'h0000, 8'h00), // R3 lower priority held back
        st(OP_WR,  4'd9,  16'h0020, 16'h000B, 8'h00),
        st(OP_RD,  4'd9,  16'h0020, 16'h0000, 8'h02), // R9 in-service view
        st(OP_WR,  4'd9,  16'h0020, 16'h000A, 8'h00),
        st(OP_RD,  4'd5,  16'h0020, 16'h0000, 8'h10), // R5 acked edge request cleared
        st(OP_WR,  4'd9,  16'h0020, 16'h0020, 8'h00),
        st(OP_INT, 4'd9,  16'h0000, 16'h0000, 8'h01), // R9 nonspecific clear
        st(OP_ACK, 4'd5,  16'h0000, 16'h0000, 8'h24),
        st(OP_WR,  4'd9,  16'h0020, 16'h0064, 8'h00),
        st(OP_INT, 4'd9,  16'h0000, 16'h0000, 8'h00), // R9 specific clear
        st(OP_REQ, 4'd2,  16'h0000, 16'h0012, 8'h00),
        st(OP_INT, 4'd2,  16'h0000, 16'h0000, 8'h00), // R2 held lines no retrigger
        st(OP_REQ, 4'd2,  16'h0000, 16'h0000, 8'h00),
        st(OP_WR,  4'd4,  16'h0021, 16'h0008, 8'h00),
        st(OP_REQ, 4'd4,  16'h0000, 16'h0008, 8'h00),
        st(OP_INT, 4'd4,  16'h0000, 16'h0000, 8'h00), // R4 masked
        st(OP_WR,  4'd4,  16'h0021, 16'h0000, 8'h00),
        st(OP_INT, 4'd4,  16'h0000, 16'h0000, 8'h01), // R4 latched while masked
        st(OP_ACK, 4'd5,  16'h0000, 16'h0000, 8'h23),
        st(OP_WR,  4'd9,  16'h0020, 16'h0020, 8'h00),
        st(OP_REQ, 4'd6,  16'h0000, 16'h0800, 8'h00),
        st(OP_INT, 4'd6,  16'h0000, 16'h0000, 8'h01), // R6 cascade raises int
        st(OP_ACK, 4'd6,  16'h0000, 16'h0000, 8'h2B), // R6 secondary vector
        st(OP_WR,  4'd9,  16'h00A0, 16'h0020, 8'h00),
        st(OP_WR,  4'd9,  16'h0020, 16'h0020, 8'h00),
        st(OP_INT, 4'd6,  16'h0000, 16'h0000, 8'h00),
        st(OP_REQ, 4'd6,  16'h0000, 16'h0000, 8'h00),
        st(OP_ACK, 4'd7,  16'h0000, 16'h0000, 8'h27), // R7 primary spurious
        st(OP_WR,  4'd13, 16'h0022, 16'h00FF, 8'h00),
        st(OP_RD,  4'd13, 16'h0021, 16'h0000, 8'h00), // R13 write ignored
        st(OP_RD,  4'd13, 16'h0022, 16'h0000, 8'h00), // R13 read zero
        st(OP_WR,  4'd13, 16'h04D2, 16'h00FF, 8'h00),
        st(OP_RD,  4'd13, 16'h04D0, 16'h0000, 8'h00)
    };

    task automatic check(input int tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_step(input logic [47:0] s);
        logic [3:0]  op;
        logic [3:0]  tag;
        logic [15:0] addr;
        logic [15:0] data;
        logic [7:0]  exp;
        {op, tag, addr, data, exp} = s;
        case (op)
            OP_WR: begin
                @(negedge clk);
                io_addr_i = addr; io_wdata_i = data[7:0]; io_wr_i = 1'b1;
                @(negedge clk);
                io_wr_i = 1'b0;
            end
            OP_RD: begin
                @(negedge clk);
                io_addr_i = addr; io_rd_i = 1'b1;
                #1;
                check(int'(tag), {1'b0, io_rdata_o}, {1'b0, exp});
                io_rd_i = 1'b0;
            end
            OP_ACK: begin
                @(negedge clk);
                inta_i = 1'b1;
                @(negedge clk);
                inta_i = 1'b0;
                check(int'(tag), {vec_vld_o, vec_o}, {1'b1, exp});
            end
            OP_REQ: begin
                @(negedge clk);
                req_i = data;
                @(negedge clk);
                @(negedge clk);
            end
            OP_INT: begin
                @(negedge clk);
                check(int'(tag), {8'h00, int_o}, {8'h00, exp[0]});
            end
            default: @(negedge clk);
        endcase
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, {8'h00, int_o}, 9'h000);
        check(1, {8'h00, vec_vld_o}, 9'h000);
        run_step(st(OP_RD, 4'd1, 16'h0021, 16'h0000, 8'h00));
        run_step(st(OP_RD, 4'd1, 16'h00A1, 16'h0000, 8'h00));
        run_step(st(OP_RD, 4'd1, 16'h04D0, 16'h0000, 8'h00));
        run_step(st(OP_RD, 4'd1, 16'h04D1, 16'h0000, 8'h00));

        for (int i = 0; i < NSTEP; i++) run_step(STEPS[i]);

        // R8 secondary spurious: cascade edge latched, then secondary line masked
        run_step(st(OP_REQ, 4'd8, 16'h0000, 16'h0100, 8'h00));
        run_step(st(OP_WR,  4'd8, 16'h00A1, 16'h0001, 8'h00));
        run_step(st(OP_INT, 4'd8, 16'h0000, 16'h0000, 8'h01));
        run_step(st(OP_ACK, 4'd8, 16'h0000, 16'h0000, 8'h2F));
        run_step(st(OP_WR,  4'd8, 16'h0020, 16'h0020, 8'h00));
        run_step(st(OP_INT, 4'd8, 16'h0000, 16'h0000, 8'h00));
        run_step(st(OP_WR,  4'd8, 16'h00A1, 16'h0000, 8'h00));
        run_step(st(OP_IDLE, 4'd8, 16'h0000, 16'h0000, 8'h00));
        run_step(st(OP_INT, 4'd6, 16'h0000, 16'h0000, 8'h01));
        run_step(st(OP_ACK, 4'd6, 16'h0000, 16'h0000, 8'h28));
        run_step(st(OP_WR,  4'd9, 16'h00A0, 16'h0020, 8'h00));
        run_step(st(OP_WR,  4'd9, 16'h0020, 16'h0020, 8'h00));
        run_step(st(OP_REQ, 4'd8, 16'h0000, 16'h0000, 8'h00));

        // R11 level-triggered line stays pending through acknowledge
        run_step(st(OP_WR,  4'd11, 16'h04D0, 16'h0008, 8'h00));
        run_step(st(OP_REQ, 4'd11, 16'h0000, 16'h0008, 8'h00));
        run_step(st(OP_INT, 4'd11, 16'h0000, 16'h0000, 8'h01));
        run_step(st(OP_ACK, 4'd11, 16'h0000, 16'h0000, 8'h23));
        run_step(st(OP_RD,  4'd11, 16'h0020, 16'h0000, 8'h08));
        run_step(st(OP_WR,  4'd11, 16'h0020, 16'h0020, 8'h00));
        run_step(st(OP_INT, 4'd11, 16'h0000, 16'h0000, 8'h01));
        run_step(st(OP_REQ, 4'd11, 16'h0000, 16'h0000, 8'h00));
        run_step(st(OP_INT, 4'd11, 16'h0000, 16'h0000, 8'h00));
        run_step(st(OP_WR,  4'd11, 16'h04D0, 16'h0000, 8'h00));

        // R5 no vector strobe without acknowledge
        @(negedge clk);
        check(5, {8'h00, vec_vld_o}, 9'h000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule